// File: doc/BRIEF.md
# Hold-Mode Power Controller

This block tracks the operating state of a small 4-bit processor core: running, hold or stop. A one-cycle strobe, decoded from the core's hold instruction, parks the core in hold. While in hold the block drops the CPU clock enable. The oscillator, timer, serial port and interrupt-capable pins are clocked outside this block and keep running. A separate strobe sends the core into stop. This block leaves stop only through reset, because stop release is handled elsewhere.

Software decides which events may end hold. It does this by writing release-enable bits into three nibble-wide registers on a plain register bus. A bus write takes effect at the clock edge at which `bus_we` is high. Reads are combinational from `bus_addr`. The bus has no handshake, so it never applies back-pressure. Six wake sources exist. Three are synchronous requests: the external interrupt, the serial port and the comparator. Three are asynchronous wake pins, each taken through a two-flop synchronizer and an edge detector. When an enabled source fires during hold, the controller returns to running and raises the CPU clock enable. It also pulses a vector request that carries a source code, so the core enters its interrupt routine instead of simply resuming.

Top module: `hold_ctl`

## Requirements
- R1: After reset `mode` is 0 (running), `cpu_clk_en` is 1, `vec_req` is 0 and all three registers read 0. Leaving any state through reset never produces a vector request.
- R2: A `hold_stb` in the running state puts `mode` at 1 (hold) with `cpu_clk_en` low from the next cycle. A further `hold_stb` while in hold has no effect.
- R3: A `stop_stb` in the running state puts `mode` at 2 (stop) with `cpu_clk_en` low. It takes precedence over a `hold_stb` in the same cycle. Stop is left only by reset: neither wake sources nor strobes change it.
- R4: The register at address 0x36 stores and returns all 4 bits. At 0x37 and 0x38, bit 3 is reserved, ignores writes and reads 0. Any other address reads 0 and ignores writes.
- R5: In hold, an enabled wake source returns `mode` to 0 with `cpu_clk_en` high one cycle later. In that same cycle `vec_req` pulses for exactly one cycle, and `vec_src` carries the source code: 1 external interrupt, 2 serial port, 3 comparator, 4 wake pin 0, 5 wake pin 1, 6 wake pin 2.
- R6: A source whose enable bit is 0 does not end hold. Sources that fire outside hold produce no `vec_req`.
- R7: The contents of register 0x36 never influence release.
- R8: In register 0x37, bit 2 enables the external interrupt, bit 1 the serial port and bit 0 the comparator. In 0x38, bit 2 enables wake pin 0, bit 1 wake pin 1 and bit 0 wake pin 2.
- R9: A wake pin wakes only on a high-to-low transition. The wake appears on the third rising clock edge after the pin falls. A pin that is already low when hold begins, and any rising transition, cause no wake.
- R10: When several enabled sources fire in the same cycle, the lowest source code is reported.
- R11: Wake qualification uses the enable bits held before the clock edge. A register write in the same cycle as a source event affects only later events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| hold_stb | input | 1 | One-cycle hold instruction strobe |
| stop_stb | input | 1 | One-cycle stop instruction strobe |
| bus_we | input | 1 | Register write enable |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 4 | Register write data |
| bus_rdata | output | 4 | Register read data for bus_addr |
| ext_irq_req | input | 1 | External interrupt request, synchronous |
| ser_req | input | 1 | Serial port event, synchronous |
| cmp_req | input | 1 | Comparator event, synchronous |
| wake_pin | input | 3 | Asynchronous wake pins, idle high |
| mode | output | 2 | 0 running, 1 hold, 2 stop |
| cpu_clk_en | output | 1 | CPU clock enable |
| vec_req | output | 1 | One-cycle interrupt vector request |
| vec_src | output | 3 | Source code of the wake, valid with vec_req |

## Verification
The collision of interest is a register write and a wake qualification landing in the same cycle. The bench asserts `ser_req` on the very edge that clears the serial enable, and expects a wake with code 2. It then does the reverse: it sets the enable on the same edge as the event and expects hold to persist until a later event. Simultaneous sources are also provoked, and the scoreboard judges them by the reported code.

// File: rtl/hold_ctl_pkg.sv
package hold_ctl_pkg;
  typedef enum logic [1:0] {
    MD_RUN  = 2'd0,
    MD_HOLD = 2'd1,
    MD_STOP = 2'd2
  } pmode_t;

  localparam int NSRC  = 6;
  localparam int SRC_W = $clog2(NSRC + 1);
  localparam int NPIN  = 3;
endpackage

// File: rtl/hold_wake_regs.sv
module hold_wake_regs #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] A_SCR  = 8'h36,
  parameter logic [ADDR_W-1:0] A_CORE = 8'h37,
  parameter logic [ADDR_W-1:0] A_PIN  = 8'h38
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        wdata,
  output logic [3:0]        rdata,
  output logic [2:0]        core_en,
  output logic [2:0]        pin_en
);
  logic [3:0] scratch_q;
  logic [2:0] core_q, pin_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scratch_q <= '0;
      core_q    <= '0;
      pin_q     <= '0;
    end else if (we) begin
      if (addr == A_SCR)  scratch_q <= wdata;
      if (addr == A_CORE) core_q    <= wdata[2:0];
      if (addr == A_PIN)  pin_q     <= wdata[2:0];
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == A_SCR)       rdata = scratch_q;
    else if (addr == A_CORE) rdata = {1'b0, core_q};
    else if (addr == A_PIN)  rdata = {1'b0, pin_q};
  end

  assign core_en = core_q;
  assign pin_en  = pin_q;
endmodule

// File: rtl/hold_pin_edge.sv
module hold_pin_edge #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_raw,
  output logic [N-1:0] fall
);
  for (genvar g = 0; g < N; g++) begin : g_pin
    logic [2:0] sh;
    always_ff @(posedge clk) begin
      if (!rst_n) sh <= 3'b111;
      else        sh <= {sh[1:0], pin_raw[g]};
    end
    assign fall[g] = sh[2] & ~sh[1];
  end
endmodule

// File: rtl/hold_mode_fsm.sv
module hold_mode_fsm
  import hold_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold_stb,
  input  logic             stop_stb,
  input  logic [NSRC-1:0]  wake_vec,
  output pmode_t           mode,
  output logic             vec_req,
  output logic [SRC_W-1:0] vec_src
);
  logic [SRC_W-1:0] code;

  always_comb begin
    code = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (wake_vec[i]) code = SRC_W'(i + 1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode    <= MD_RUN;
      vec_req <= 1'b0;
      vec_src <= '0;
    end else begin
      vec_req <= 1'b0;
      vec_src <= '0;
      case (mode)
        MD_RUN: begin
          if (stop_stb)      mode <= MD_STOP;
          else if (hold_stb) mode <= MD_HOLD;
        end
        MD_HOLD: begin
          if (|wake_vec) begin
            mode    <= MD_RUN;
            vec_req <= 1'b1;
            vec_src <= code;
          end
        end
        MD_STOP: mode <= MD_STOP;
        default: mode <= MD_RUN;
      endcase
    end
  end
endmodule

// File: rtl/hold_ctl.sv
module hold_ctl
  import hold_ctl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] A_SCR  = 8'h36,
  parameter logic [ADDR_W-1:0] A_CORE = 8'h37,
  parameter logic [ADDR_W-1:0] A_PIN  = 8'h38
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold_stb,
  input  logic              stop_stb,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_wdata,
  output logic [3:0]        bus_rdata,
  input  logic              ext_irq_req,
  input  logic              ser_req,
  input  logic              cmp_req,
  input  logic [NPIN-1:0]   wake_pin,
  output logic [1:0]        mode,
  output logic              cpu_clk_en,
  output logic              vec_req,
  output logic [SRC_W-1:0]  vec_src
);
  logic [2:0]      core_en, pin_en;
  logic [NPIN-1:0] pin_fall;
  logic [NSRC-1:0] wake_vec;
  pmode_t          mode_q;

  hold_wake_regs #(.ADDR_W(ADDR_W), .A_SCR(A_SCR), .A_CORE(A_CORE), .A_PIN(A_PIN)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .rdata(bus_rdata), .core_en(core_en), .pin_en(pin_en)
  );

  hold_pin_edge #(.N(NPIN)) u_edge (
    .clk(clk), .rst_n(rst_n), .pin_raw(wake_pin), .fall(pin_fall)
  );

  // index order is priority order: index 0 wins
  assign wake_vec = {pin_en[0] & pin_fall[2],
                     pin_en[1] & pin_fall[1],
                     pin_en[2] & pin_fall[0],
                     core_en[0] & cmp_req,
                     core_en[1] & ser_req,
                     core_en[2] & ext_irq_req};

  hold_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .hold_stb(hold_stb), .stop_stb(stop_stb),
    .wake_vec(wake_vec), .mode(mode_q), .vec_req(vec_req), .vec_src(vec_src)
  );

  assign mode       = mode_q;
  assign cpu_clk_en = (mode_q == MD_RUN);
endmodule

// File: rtl/hold_ctl_chk.sv
module hold_ctl_chk
  import hold_ctl_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             hold_stb,
  input logic             stop_stb,
  input logic [1:0]       mode,
  input logic             cpu_clk_en,
  input logic             vec_req,
  input logic [SRC_W-1:0] vec_src
);
  // R5
  vec_from_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req |-> ($past(mode) == 2'(MD_HOLD) && mode == 2'(MD_RUN) && cpu_clk_en));

  // R5
  vec_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req |=> !vec_req);

  // R5
  vec_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req |-> (vec_src != '0 && vec_src <= SRC_W'(NSRC)));

  // R2
  hold_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'(MD_RUN) && hold_stb && !stop_stb) |=> (mode == 2'(MD_HOLD) && !cpu_clk_en));

  // R3
  stop_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'(MD_RUN) && stop_stb) |=> (mode == 2'(MD_STOP)));

  // R3
  stop_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'(MD_STOP)) |=> (mode == 2'(MD_STOP) && !vec_req && !cpu_clk_en));

  // R6
  no_vec_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'(MD_HOLD)) |=> !vec_req);
endmodule

bind hold_ctl hold_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hold_stb(hold_stb), .stop_stb(stop_stb),
  .mode(mode), .cpu_clk_en(cpu_clk_en), .vec_req(vec_req), .vec_src(vec_src)
);

// File: tb/hold_ctl_test.sv
`timescale 1ns/1ps
module hold_ctl_test;
  logic       clk = 0, rst_n = 0;
  logic       hold_stb = 0, stop_stb = 0, bus_we = 0;
  logic [7:0] bus_addr = 0;
  logic [3:0] bus_wdata = 0, bus_rdata;
  logic       ext_irq_req = 0, ser_req = 0, cmp_req = 0;
  logic [2:0] wake_pin = 3'b111;
  logic [1:0] mode;
  logic       cpu_clk_en, vec_req;
  logic [2:0] vec_src;

  int nchk = 0, nfail = 0;
  logic [2:0] expq[$];

  always #2.5 clk = ~clk;

  hold_ctl uut (
    .clk(clk), .rst_n(rst_n), .hold_stb(hold_stb), .stop_stb(stop_stb),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_irq_req(ext_irq_req), .ser_req(ser_req), .cmp_req(cmp_req), .wake_pin(wake_pin),
    .mode(mode), .cpu_clk_en(cpu_clk_en), .vec_req(vec_req), .vec_src(vec_src)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: every vector request must match the next expected item
  always @(negedge clk) begin
    if (rst_n && vec_req) begin
      nchk++;
      if (expq.size() == 0) begin
        nfail++;
        $display("FAIL R6 actual=vec_req code %0d expected=no request", vec_src);
      end else begin
        logic [2:0] e;
        e = expq.pop_front();
        if (vec_src !== e) begin
          nfail++;
          $display("FAIL R5/R10 actual=%0d expected=%0d", vec_src, e);
        end
      end
    end
  end

  task automatic wr(logic [7:0] a, logic [3:0] d);
    @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(string req, logic [7:0] a, logic [3:0] exp);
    @(negedge clk); bus_addr = a; #1;
    chk(req, 8'(bus_rdata), 8'(exp));
  endtask

  task automatic go_hold();
    @(negedge clk); hold_stb = 1;
    @(negedge clk); hold_stb = 0;
    chk("R2 mode", 8'(mode), 8'd1);
    chk("R2 clk_en", 8'(cpu_clk_en), 8'd0);
  endtask

  // pulse {ext, ser, cmp} for one cycle
  task automatic fire(logic [2:0] s);
    @(negedge clk); {ext_irq_req, ser_req, cmp_req} = s;
    @(negedge clk); {ext_irq_req, ser_req, cmp_req} = 3'b000;
  endtask

  task automatic expect_run(string req);
    chk({req, " mode"}, 8'(mode), 8'd0);
    chk({req, " clk_en"}, 8'(cpu_clk_en), 8'd1);
  endtask

  initial begin
    #(5.0 * 20000);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    @(negedge clk);
    expect_run("R1");
    chk("R1 vec_req", 8'(vec_req), 8'd0);
    rd("R1 scratch", 8'h36, 4'h0);
    rd("R1 core", 8'h37, 4'h0);
    rd("R1 pin", 8'h38, 4'h0);

    // R4 register access
    wr(8'h36, 4'hA); rd("R4 scratch", 8'h36, 4'hA);
    wr(8'h37, 4'hF); rd("R4 core rsvd", 8'h37, 4'h7);
    wr(8'h38, 4'hF); rd("R4 pin rsvd", 8'h38, 4'h7);
    wr(8'h40, 4'h5); rd("R4 unmapped", 8'h40, 4'h0);
    rd("R4 scratch kept", 8'h36, 4'hA);

    // R6 R7 R8: only ext interrupt enabled, scratch all ones
    wr(8'h36, 4'hF); wr(8'h37, 4'h4); wr(8'h38, 4'h0);
    go_hold();
    fire(3'b011);
    @(negedge clk); wake_pin = 3'b000;
    repeat (4) @(negedge clk); wake_pin = 3'b111;
    repeat (4) @(negedge clk);
    chk("R6 R7 stays hold", 8'(mode), 8'd1);
    @(negedge clk); hold_stb = 1;
    @(negedge clk); hold_stb = 0;
    chk("R2 strobe in hold", 8'(mode), 8'd1);
    expq.push_back(3'd1);
    fire(3'b100);
    expect_run("R5 R8 ext");
    @(negedge clk);
    chk("R5 pulse ends", 8'(vec_req), 8'd0);

    // R9 wake pin 0: low on entry, rising, then falling
    wr(8'h37, 4'h0); wr(8'h38, 4'h4);
    @(negedge clk); wake_pin[0] = 1'b0;
    repeat (4) @(negedge clk);
    go_hold();
    repeat (5) @(negedge clk);
    chk("R9 low on entry", 8'(mode), 8'd1);
    wake_pin[0] = 1'b1;
    repeat (5) @(negedge clk);
    chk("R9 rising", 8'(mode), 8'd1);
    expq.push_back(3'd4);
    wake_pin[0] = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 latency 2", 8'(mode), 8'd1);
    @(negedge clk);
    expect_run("R9 latency 3");
    wake_pin[0] = 1'b1;
    repeat (4) @(negedge clk);

    // R8 R10 pins 1 and 2 together: pin 1 wins
    wr(8'h38, 4'h3);
    go_hold();
    expq.push_back(3'd5);
    wake_pin[2:1] = 2'b00;
    repeat (3) @(negedge clk);
    expect_run("R10 pins");
    wake_pin = 3'b111;
    repeat (4) @(negedge clk);
    go_hold();
    expq.push_back(3'd6);
    wake_pin[2] = 1'b0;
    repeat (3) @(negedge clk);
    expect_run("R8 pin2");
    wake_pin = 3'b111;
    repeat (4) @(negedge clk);

    // R10 core sources priority
    wr(8'h38, 4'h0); wr(8'h37, 4'h7);
    go_hold(); expq.push_back(3'd1); fire(3'b111); expect_run("R10 all");
    go_hold(); expq.push_back(3'd2); fire(3'b011); expect_run("R10 ser cmp");
    go_hold(); expq.push_back(3'd3); fire(3'b001); expect_run("R10 cmp");

    // R11 write and event in the same cycle
    wr(8'h37, 4'h2);
    go_hold();
    expq.push_back(3'd2);
    @(negedge clk); bus_we = 1; bus_addr = 8'h37; bus_wdata = 4'h0; ser_req = 1;
    @(negedge clk); bus_we = 0; ser_req = 0;
    expect_run("R11 clear same cycle");
    rd("R11 cleared", 8'h37, 4'h0);
    go_hold();
    @(negedge clk); bus_we = 1; bus_addr = 8'h37; bus_wdata = 4'h2; ser_req = 1;
    @(negedge clk); bus_we = 0; ser_req = 0;
    chk("R11 set same cycle", 8'(mode), 8'd1);
    expq.push_back(3'd2);
    fire(3'b010);
    expect_run("R11 later event");

    // R6 events while running
    wr(8'h37, 4'h7);
    fire(3'b111);
    repeat (2) @(negedge clk);
    expect_run("R6 running");

    // R3 stop wins and is sticky
    @(negedge clk); hold_stb = 1; stop_stb = 1;
    @(negedge clk); hold_stb = 0; stop_stb = 0;
    chk("R3 stop", 8'(mode), 8'd2);
    chk("R3 clk_en", 8'(cpu_clk_en), 8'd0);
    fire(3'b111);
    @(negedge clk); hold_stb = 1;
    @(negedge clk); hold_stb = 0;
    chk("R3 sticky", 8'(mode), 8'd2);
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk); rst_n = 1;
    @(negedge clk);
    expect_run("R1 after reset");
    chk("R1 no vec", 8'(vec_req), 8'd0);
    rd("R1 core cleared", 8'h37, 4'h0);

    repeat (3) @(negedge clk);
    chk("R5 queue drained", 8'(expq.size()), 8'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule